// File: doc/BRIEF.md
# Compare Match Port Controller

This block watches a free-running timer value and compares it against three programmable 16-bit match values. A compare is evaluated only in a cycle where the timer reports that it has just advanced. Each match slot drives a different action on a shared 8-bit output latch. Slot 0 forces selected low bits high. Slot 1 forces selected low bits low. Slot 2 inverts selected high bits. Each action is gated by its own per-bit enable mask.

Every match also raises a one-cycle flag pulse for an interrupt collector elsewhere in the chip. That pulse is posted one cycle after the latch reacts. Software may load the latch directly. In any cycle where a compare action hits a bit, that action takes precedence over the software value for that bit.

The timer itself, the pad logic and the interrupt register that gathers the flags all live outside this block.

Top module: `cmp_port_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `port_q`, `tgl_state` and `cmp_flag` are all zero, and every match register holds 0.
- R2: A match is detected only when `tmr_inc` is 1 and `tmr_val` equals the slot's match register. With `tmr_inc` at 0, or with an unequal value, neither the latch nor the flags change.
- R3: If slot k matches in cycle t, `cmp_flag[k]` is 1 during cycle t+2 only, one cycle after `port_q` shows the action (which it does in cycle t+1). Bit k of `cmp_flag` corresponds to slot k (0, 1, 2).
- R4: A slot-0 match sets each bit i of `port_q[5:0]` for which `set_en[i]` is 1.
- R5: A slot-1 match clears each bit i of `port_q[5:0]` for which `clr_en[i]` is 1.
- R6: A slot-2 match inverts `port_q[6]` when `tgl_en[0]` is 1, and inverts `port_q[7]` when `tgl_en[1]` is 1.
- R7: When slot 0 and slot 1 match in the same cycle and both enables select a bit, that bit ends at 0.
- R8: A high `sw_we` loads `sw_wdata` into `port_q` on the clock edge. For any bit acted on by a compare in the same cycle, the compare result replaces the written value. A toggle inverts the latch value from before the write.
- R9: `tgl_state` always equals `port_q[7:6]`.
- R10: A write to match register `cfg_sel` (0, 1, 2; 3 is ignored) takes effect from the next cycle. A timer advance in the same cycle as the write is compared against the old value.
- R11: Slots 0 and 1 never change `port_q[7:6]`, and slot 2 never changes `port_q[5:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_inc | input | 1 | Timer advanced this cycle; `tmr_val` holds the new count |
| tmr_val | input | 16 | Current timer count |
| cfg_we | input | 1 | Write strobe for a match register |
| cfg_sel | input | 2 | Match register index for `cfg_we` |
| cfg_wdata | input | 16 | Match value to store |
| set_en | input | 6 | Per-bit enables for the slot-0 set action |
| clr_en | input | 6 | Per-bit enables for the slot-1 clear action |
| tgl_en | input | 2 | Per-bit enables for the slot-2 invert action on bits 7:6 |
| sw_we | input | 1 | Direct latch write strobe |
| sw_wdata | input | 8 | Direct latch write value |
| port_q | output | 8 | Output latch |
| tgl_state | output | 2 | Status copy of the two toggled bits |
| cmp_flag | output | 3 | Delayed one-cycle match pulses, one per slot |

## Verification
The set and clear actions are swept over all 64 enable masks. The set sweep starts from an all-zero latch and the clear sweep from an all-one latch, so any mask bit that is dropped, shifted or spilled into bits 7:6 shows up directly. A third sweep makes slots 0 and 1 match together with a full set mask under every clear mask, which separates clear-priority from set-priority. The toggle enables are tried in all four combinations with two successive matches, so both inversion and restoration are seen. Further runs overlap software writes with compare hits and issue match-register writes in the same cycle as a timer advance. Non-advancing and off-by-one timer values confirm that nothing fires.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned CMP_N = 3;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SLOT_SET = 2'd0,
    SLOT_CLR = 2'd1,
    SLOT_TGL = 2'd2
  } slot_e;
endpackage

// File: rtl/cmp_bank.sv
module cmp_bank
  import cmp_pkg::*;
#(
  parameter int unsigned TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [TMR_W-1:0]  cfg_wdata,
  input  logic              tmr_inc,
  input  logic [TMR_W-1:0]  tmr_val,
  output logic [CMP_N-1:0]  hit_now,
  output logic [CMP_N-1:0]  hit_q
);
  logic [TMR_W-1:0] match_r [CMP_N];

  for (genvar k = 0; k < CMP_N; k++) begin : g_slot
    // written value is visible to the comparator only after the edge
    always_ff @(posedge clk) begin
      if (rst) begin
        match_r[k] <= '0;
      end else if (cfg_we && (cfg_sel == SEL_W'(k))) begin
        match_r[k] <= cfg_wdata;
      end
    end

    always_comb begin
      hit_now[k] = tmr_inc && (tmr_val == match_r[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= '0;
    end else begin
      hit_q <= hit_now;
    end
  end
endmodule

// File: rtl/cmp_flag_stage.sv
module cmp_flag_stage
  import cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CMP_N-1:0] hit_q,
  output logic [CMP_N-1:0] flag_q
);
  // second register stage: the flag is posted one cycle after the latch acts
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else begin
      flag_q <= hit_q;
    end
  end
endmodule

// File: rtl/cmp_port_latch.sv
module cmp_port_latch
  import cmp_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned SR_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CMP_N-1:0]     hit_now,
  input  logic [SR_W-1:0]      set_en,
  input  logic [SR_W-1:0]      clr_en,
  input  logic [PORT_W-SR_W-1:0] tgl_en,
  input  logic                 sw_we,
  input  logic [PORT_W-1:0]    sw_wdata,
  output logic [PORT_W-1:0]    port_q
);
  localparam int unsigned TGL_W = PORT_W - SR_W;

  logic [PORT_W-1:0] set_m, clr_m, tgl_m, touched, base, nxt;

  always_comb begin
    set_m   = {{TGL_W{1'b0}}, set_en & {SR_W{hit_now[SLOT_SET]}}};
    clr_m   = {{TGL_W{1'b0}}, clr_en & {SR_W{hit_now[SLOT_CLR]}}};
    tgl_m   = {tgl_en & {TGL_W{hit_now[SLOT_TGL]}}, {SR_W{1'b0}}};
    touched = set_m | clr_m | tgl_m;
    base    = sw_we ? sw_wdata : port_q;
    // clear beats set; toggle inverts the pre-write latch value
    nxt     = (base & ~touched) | (set_m & ~clr_m) | (tgl_m & ~port_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '0;
    end else begin
      port_q <= nxt;
    end
  end
endmodule

// File: rtl/cmp_port_ctrl.sv
module cmp_port_ctrl
  import cmp_pkg::*;
#(
  parameter int unsigned TMR_W  = 16,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned SR_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tmr_inc,
  input  logic [TMR_W-1:0]       tmr_val,
  input  logic                   cfg_we,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic [TMR_W-1:0]       cfg_wdata,
  input  logic [SR_W-1:0]        set_en,
  input  logic [SR_W-1:0]        clr_en,
  input  logic [PORT_W-SR_W-1:0] tgl_en,
  input  logic                   sw_we,
  input  logic [PORT_W-1:0]      sw_wdata,
  output logic [PORT_W-1:0]      port_q,
  output logic [PORT_W-SR_W-1:0] tgl_state,
  output logic [CMP_N-1:0]       cmp_flag
);
  logic [CMP_N-1:0] hit_now;
  logic [CMP_N-1:0] hit_q;

  cmp_bank #(.TMR_W(TMR_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .tmr_inc   (tmr_inc),
    .tmr_val   (tmr_val),
    .hit_now   (hit_now),
    .hit_q     (hit_q)
  );

  cmp_flag_stage u_flag (
    .clk    (clk),
    .rst    (rst),
    .hit_q  (hit_q),
    .flag_q (cmp_flag)
  );

  cmp_port_latch #(.PORT_W(PORT_W), .SR_W(SR_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .hit_now  (hit_now),
    .set_en   (set_en),
    .clr_en   (clr_en),
    .tgl_en   (tgl_en),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .port_q   (port_q)
  );

  assign tgl_state = port_q[PORT_W-1:SR_W];
endmodule

// File: rtl/cmp_port_ctrl_chk.sv
module cmp_port_ctrl_chk
  import cmp_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned SR_W   = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tmr_inc,
  input logic [SR_W-1:0]        set_en,
  input logic [SR_W-1:0]        clr_en,
  input logic [PORT_W-SR_W-1:0] tgl_en,
  input logic                   sw_we,
  input logic [PORT_W-1:0]      port_q,
  input logic [PORT_W-SR_W-1:0] tgl_state,
  input logic [CMP_N-1:0]       cmp_flag,
  input logic [CMP_N-1:0]       hit_now
);
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (port_q == '0 && cmp_flag == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tmr_inc && !sw_we) |=> $stable(port_q));

  p_flag_late_r3: assert property (@(posedge clk) disable iff (rst)
    (|hit_now) |=> ##1 (cmp_flag == $past(hit_now, 2)));

  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    (hit_now[SLOT_SET] && !hit_now[SLOT_CLR]) |=>
      ((port_q[SR_W-1:0] & $past(set_en)) == $past(set_en)));

  // clear result also covers simultaneous set (R7)
  p_clr_wins_r5_r7: assert property (@(posedge clk) disable iff (rst)
    hit_now[SLOT_CLR] |=> ((port_q[SR_W-1:0] & $past(clr_en)) == '0));

  p_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_now[SLOT_TGL] && !sw_we) |=>
      (port_q[PORT_W-1:SR_W] == ($past(port_q[PORT_W-1:SR_W]) ^ $past(tgl_en))));

  p_status_r9: assert property (@(posedge clk) disable iff (rst)
    tgl_state == port_q[PORT_W-1:SR_W]);

  p_no_cross_r11: assert property (@(posedge clk) disable iff (rst)
    (!hit_now[SLOT_TGL] && !sw_we) |=> $stable(port_q[PORT_W-1:SR_W]));
endmodule

bind cmp_port_ctrl cmp_port_ctrl_chk #(.PORT_W(PORT_W), .SR_W(SR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tmr_inc   (tmr_inc),
  .set_en    (set_en),
  .clr_en    (clr_en),
  .tgl_en    (tgl_en),
  .sw_we     (sw_we),
  .port_q    (port_q),
  .tgl_state (tgl_state),
  .cmp_flag  (cmp_flag),
  .hit_now   (hit_now)
);

// File: tb/cmp_port_ctrl_bench.sv
module cmp_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tmr_inc = 1'b0;
  logic [15:0] tmr_val = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [5:0]  set_en = '0;
  logic [5:0]  clr_en = '0;
  logic [1:0]  tgl_en = '0;
  logic        sw_we = 1'b0;
  logic [7:0]  sw_wdata = '0;
  logic [7:0]  port_q;
  logic [1:0]  tgl_state;
  logic [2:0]  cmp_flag;

  cmp_port_ctrl u_cmp_port_ctrl (
    .clk(clk), .rst(rst), .tmr_inc(tmr_inc), .tmr_val(tmr_val),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .set_en(set_en), .clr_en(clr_en), .tgl_en(tgl_en),
    .sw_we(sw_we), .sw_wdata(sw_wdata),
    .port_q(port_q), .tgl_state(tgl_state), .cmp_flag(cmp_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  logic        done = 1'b0;
  logic [15:0] sh_cmp [3];
  logic [7:0]  exp_port;
  logic [2:0]  prev_hit;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_port(input logic [7:0] old, input logic we,
      input logic [7:0] wd, input logic [2:0] h, input logic [5:0] se,
      input logic [5:0] ce, input logic [1:0] te);
    logic [7:0] r;
    r = we ? wd : old;
    for (int i = 0; i < 6; i++) begin
      if (h[1] && ce[i]) r[i] = 1'b0;
      else if (h[0] && se[i]) r[i] = 1'b1;
    end
    for (int j = 0; j < 2; j++)
      if (h[2] && te[j]) r[6+j] = ~old[6+j];
    return r;
  endfunction

  task automatic step(input logic inc, input logic [15:0] val, input logic cwe,
      input logic [1:0] csel, input logic [15:0] cwd, input logic swe,
      input logic [7:0] swd, input string req);
    logic [2:0] h;
    logic [2:0] exp_flag;
    tmr_inc = inc; tmr_val = val; cfg_we = cwe; cfg_sel = csel; cfg_wdata = cwd;
    sw_we = swe; sw_wdata = swd;
    for (int k = 0; k < 3; k++) h[k] = inc && (val == sh_cmp[k]);
    exp_port = ref_port(exp_port, swe, swd, h, set_en, clr_en, tgl_en);
    exp_flag = prev_hit;
    prev_hit = h;
    if (cwe && csel != 2'd3) sh_cmp[csel] = cwd;
    @(posedge clk); #1;
    chk(port_q == exp_port, req, port_q, exp_port);
    chk(cmp_flag == exp_flag, {req, "/R3 flag"}, cmp_flag, exp_flag);
    chk(tgl_state == exp_port[7:6], "R9 status", tgl_state, exp_port[7:6]);
  endtask

  task automatic idle(input string req);
    step(1'b0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 3; k++) sh_cmp[k] = '0;
    exp_port = '0; prev_hit = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(port_q == 8'h00, "R1 latch in reset", port_q, 0);
    chk(cmp_flag == 3'b000, "R1 flags in reset", cmp_flag, 0);
    rst = 1'b0;
    idle("R1 after reset");

    // R10: write while the timer hits the new value; old value (0) is compared
    step(1'b1, 16'h0100, 1'b1, 2'd0, 16'h0100, 1'b0, 8'h0, "R10 write cmp0");
    step(1'b1, 16'h0200, 1'b1, 2'd1, 16'h0200, 1'b0, 8'h0, "R10 write cmp1");
    step(1'b1, 16'h0300, 1'b1, 2'd2, 16'h0300, 1'b0, 8'h0, "R10 write cmp2");
    step(1'b1, 16'h0400, 1'b1, 2'd3, 16'h0400, 1'b0, 8'h0, "R10 ignored sel3");
    idle("R10 settle");
    idle("R10 settle");

    // R4 sweep of set mask from an all-zero latch
    for (int m = 0; m < 64; m++) begin
      set_en = 6'(m);
      step(1'b0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b1, 8'h00, "R8 clear latch");
      step(1'b1, 16'h0100, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0, "R4 set sweep");
    end
    idle("R3 tail");
    // R2: no advance, or advance to an unequal value
    set_en = 6'h3F;
    step(1'b0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b1, 8'h00, "R8 clear latch");
    step(1'b0, 16'h0100, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0, "R2 no advance");
    step(1'b1, 16'h0101, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0, "R2 unequal");
    idle("R2 settle");
    idle("R2 settle");

    // R5 sweep of clear mask from an all-one latch (bits 7:6 must stay, R11)
    for (int m = 0; m < 64; m++) begin
      clr_en = 6'(m);
      step(1'b0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b1, 8'hFF, "R8 fill latch");
      step(1'b1, 16'h0200, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0, "R5 clear sweep / R11");
    end
    idle("R3 tail");

    // R6: every toggle-enable combination, two matches (invert, restore)
    for (int t = 0; t < 4; t++) begin
      tgl_en = 2'(t);
      step(1'b0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b1, 8'h15, "R8 load");
      step(1'b1, 16'h0300, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0, "R6 toggle / R11");
      step(1'b1, 16'h0300, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0, "R6 toggle back");
    end
    idle("R3 tail");

    // R7: slots 0 and 1 matching together
    step(1'b0, 16'h0, 1'b1, 2'd1, 16'h0100, 1'b0, 8'h0, "R10 move cmp1");
    set_en = 6'h3F;
    for (int m = 0; m < 64; m++) begin
      clr_en = 6'(m);
      step(1'b0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b1, 8'h00, "R8 clear latch");
      step(1'b1, 16'h0100, 1'b0, 2'd0, 16'h0, 1'b0, 8'h0, "R7 clear wins");
    end
    step(1'b0, 16'h0, 1'b1, 2'd1, 16'h0200, 1'b0, 8'h0, "R10 restore cmp1");

    // R8: software write in the same cycle as compare actions
    clr_en = 6'h00; tgl_en = 2'b11;
    for (int m = 0; m < 64; m += 7) begin
      set_en = 6'(m);
      step(1'b1, 16'h0100, 1'b0, 2'd0, 16'h0, 1'b1, 8'hA4, "R8 write vs set");
      step(1'b1, 16'h0300, 1'b0, 2'd0, 16'h0, 1'b1, 8'h5A, "R8 write vs toggle");
    end
    clr_en = 6'h2A;
    step(1'b1, 16'h0200, 1'b0, 2'd0, 16'h0, 1'b1, 8'hFF, "R8 write vs clear");
    idle("R3 tail");
    idle("R3 tail");

    finish_run();
  end
endmodule